// File: doc/BRIEF.md
# Serial Three-Wire EEPROM Slave Engine

This block is the device side of a three-wire serial EEPROM holding 128 words of 16 bits in a register array. It samples a select line, a serial clock and a serial data input with the system clock, frames each instruction from a start bit, a two-bit opcode and a seven-bit word address, and answers on a serial data output that has its own output enable. Reads stream words for as long as select stays high. Writes cover one word, a page of up to four words, or the whole array.

Programming is self-timed: when select falls at the end of a valid write, the array is updated and a busy interval of a parameterised number of system clocks begins. While that interval runs, the serial clock may stop or keep toggling. Raising select drives the output with a busy level and then a ready level. Instructions that arrive while programming is pending are ignored. Commands that set the protected area are decoded by a separate block and have no effect here.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the output enable is low and every word of the array reads back as 0.
- R2: An instruction is a 1 start bit, then a 2-bit opcode, then a 7-bit address, all MSB first and sampled on rising serial clock edges. Zeros before the start bit are ignored. Opcodes: 10 read, 01 write, 11 page write, 00 extended. An extended code with address bits [6:5] = 01 is write-all. Every other extended code changes nothing and starts no programming.
- R3: On the rising edge that samples the last address bit of a read, the output enable rises and the output shows a dummy 0. Each of the next 16 rising edges shows one data bit, MSB first.
- R4: A read continues into the next word with no dummy bit while select stays high. The address increments after each word and wraps from 127 to 0.
- R5: A write takes 16 data bits, MSB first, and programs exactly one word when select falls. Data bits after the 16th are ignored.
- R6: A page write programs 1 to 4 whole words into address, address+1, and so on, modulo 128. Bits after the fourth word are ignored.
- R7: Write-all sets every word of the array to its 16-bit data word.
- R8: For PROG_CYCLES system clocks after programming starts, select high drives the output with 0 (busy). After that it drives 1 (ready) until select falls.
- R9: An instruction sent while programming is pending changes no memory.
- R10: If select falls before the header or a data word is complete, the instruction is aborted: memory is unchanged and no busy interval starts.
- R11: The output enable is low whenever select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output, carrying read data or ready/busy |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
A wrong pointer or shift state in this block shows up as a wrong bit on sdo in the serial clock period where it happens. A miscounted bit position shows up in the first word read after it. A corrupted array word or a misaddressed page stays hidden until that address is read, so every address is written with a distinct value and the whole array is read back in one stream that crosses the wrap point. A wrong busy counter or a stale status flag shows up as soon as select is raised: the enable or the ready level appears at the wrong time. A missed abort shows up as a changed neighbour word, or as a busy response that should not be there.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_HDR  = 3'd1,
        S_READ = 3'd2,
        S_DATA = 3'd3,
        S_DROP = 3'd4
    } mw_state_e;

    localparam logic [1:0] OP_READ   = 2'b10;
    localparam logic [1:0] OP_WRITE  = 2'b01;
    localparam logic [1:0] OP_PAGE   = 2'b11;
    localparam logic [1:0] OP_EXT    = 2'b00;
    localparam logic [1:0] EXT_WRALL = 2'b01;

endpackage

// File: rtl/mw_sync_edge.sv
module mw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sel_o,
    output logic sdi_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sel;
        logic [STAGES-1:0] sclk;
        logic [STAGES-1:0] sdi;
        logic              sclk_last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d           = sync_q;
        sync_d.sel       = {sync_q.sel[STAGES-2:0], sel_i};
        sync_d.sclk      = {sync_q.sclk[STAGES-2:0], sclk_i};
        sync_d.sdi       = {sync_q.sdi[STAGES-2:0], sdi_i};
        sync_d.sclk_last = sync_q.sclk[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sel_o  = sync_q.sel[STAGES-1];
    assign sdi_o  = sync_q.sdi[STAGES-1];
    assign rise_o = sync_q.sclk[STAGES-1] & ~sync_q.sclk_last;

    // A rising edge is never reported on two clocks in a row (R2).
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)             cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // The busy window counts down one step per system clock (R8).
    p_busy_countdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/mw_mem_array.sv
module mw_mem_array #(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter int PW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          rd_addr_i,
    output logic [DW-1:0]          rd_data_o,
    input  logic                   wr_en_i,
    input  logic                   wr_all_i,
    input  logic [AW-1:0]          wr_base_i,
    input  logic [$clog2(PW+1)-1:0] wr_cnt_i,
    input  logic [PW*DW-1:0]       wr_buf_i
);
    localparam int WORDS = 1 << AW;
    localparam int CW    = $clog2(PW + 1);

    logic [DW-1:0] mem_d [WORDS];
    logic [DW-1:0] mem_q [WORDS];

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            mem_d[w] = mem_q[w];
            if (wr_en_i && wr_all_i) begin
                mem_d[w] = wr_buf_i[DW-1:0];
            end else if (wr_en_i) begin
                for (int j = 0; j < PW; j++) begin
                    if ((CW'(j) < wr_cnt_i) && ((wr_base_i + AW'(j)) == AW'(w)))
                        mem_d[w] = wr_buf_i[j*DW +: DW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
        end else begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= mem_d[w];
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // After a write-all the first and last words agree (R7).
    p_wrall_uniform_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_all_i) |=> (mem_q[0] == mem_q[WORDS-1]));
endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
    import mw_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter int PW = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_i,
    input  logic                    sdi_i,
    input  logic                    rise_i,
    input  logic                    busy_i,
    input  logic [DW-1:0]           rd_data_i,
    output logic [AW-1:0]           rd_addr_o,
    output logic                    commit_o,
    output logic                    commit_all_o,
    output logic [AW-1:0]           commit_base_o,
    output logic [$clog2(PW+1)-1:0] commit_cnt_o,
    output logic [PW*DW-1:0]        commit_buf_o,
    output logic                    sdo_o,
    output logic                    sdo_oe_o
);
    localparam int HW   = AW + 2;
    localparam int CW   = $clog2(PW + 1);
    localparam int MAXB = (HW > DW) ? HW : DW;
    localparam int BW   = $clog2(MAXB + 1);

    typedef struct packed {
        mw_state_e       st;
        logic [BW-1:0]   cnt;
        logic [HW-2:0]   hdr;
        logic [AW-1:0]   ptr;
        logic [DW-1:0]   sh;
        logic            dout;
        logic [PW*DW-1:0] pbuf;
        logic [CW-1:0]   wcnt;
        logic [CW-1:0]   wlim;
        logic            all;
        logic            status;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [HW-1:0] hdr_full;
    logic [1:0]    op;
    logic [AW-1:0] adr;
    logic [1:0]    ext;
    logic [DW-1:0] word_in;

    assign hdr_full = {fsm_q.hdr, sdi_i};
    assign op       = hdr_full[HW-1:HW-2];
    assign adr      = hdr_full[AW-1:0];
    assign ext      = adr[AW-1:AW-2];
    assign word_in  = {fsm_q.sh[DW-2:0], sdi_i};

    assign commit_o      = (fsm_q.st == S_DATA) && !sel_i &&
                           (fsm_q.wcnt != '0) && (fsm_q.cnt == '0);
    assign commit_all_o  = fsm_q.all;
    assign commit_base_o = fsm_q.ptr;
    assign commit_cnt_o  = fsm_q.wcnt;
    assign commit_buf_o  = fsm_q.pbuf;
    assign rd_addr_o     = (fsm_q.st == S_HDR) ? adr : (fsm_q.ptr + AW'(1));

    always_comb begin
        fsm_d = fsm_q;
        if (fsm_q.status && !sel_i && !busy_i) fsm_d.status = 1'b0;

        unique case (fsm_q.st)
            S_IDLE: begin
                if (!fsm_q.status && sel_i && rise_i && sdi_i) begin
                    fsm_d.st  = S_HDR;
                    fsm_d.cnt = '0;
                end
            end
            S_HDR: begin
                if (!sel_i) begin
                    fsm_d.st = S_IDLE;
                end else if (rise_i) begin
                    fsm_d.hdr = hdr_full[HW-2:0];
                    fsm_d.cnt = fsm_q.cnt + BW'(1);
                    if (fsm_q.cnt == BW'(HW-1)) begin
                        fsm_d.cnt  = '0;
                        fsm_d.ptr  = adr;
                        fsm_d.wcnt = '0;
                        fsm_d.all  = 1'b0;
                        fsm_d.wlim = CW'(1);
                        unique case (op)
                            OP_READ: begin
                                fsm_d.st   = S_READ;
                                fsm_d.sh   = rd_data_i;
                                fsm_d.dout = 1'b0;
                            end
                            OP_WRITE: fsm_d.st = S_DATA;
                            OP_PAGE: begin
                                fsm_d.st   = S_DATA;
                                fsm_d.wlim = CW'(PW);
                            end
                            default: begin
                                if (ext == EXT_WRALL) begin
                                    fsm_d.st  = S_DATA;
                                    fsm_d.all = 1'b1;
                                end else begin
                                    fsm_d.st = S_DROP;
                                end
                            end
                        endcase
                    end
                end
            end
            S_READ: begin
                if (!sel_i) begin
                    fsm_d.st = S_IDLE;
                end else if (rise_i) begin
                    fsm_d.dout = fsm_q.sh[DW-1];
                    if (fsm_q.cnt == BW'(DW-1)) begin
                        fsm_d.sh  = rd_data_i;
                        fsm_d.ptr = fsm_q.ptr + AW'(1);
                        fsm_d.cnt = '0;
                    end else begin
                        fsm_d.sh  = {fsm_q.sh[DW-2:0], 1'b0};
                        fsm_d.cnt = fsm_q.cnt + BW'(1);
                    end
                end
            end
            S_DATA: begin
                if (!sel_i) begin
                    fsm_d.st = S_IDLE;
                    if (commit_o) fsm_d.status = 1'b1;
                end else if (rise_i && (fsm_q.wcnt != fsm_q.wlim)) begin
                    fsm_d.sh = word_in;
                    if (fsm_q.cnt == BW'(DW-1)) begin
                        for (int j = 0; j < PW; j++) begin
                            if (CW'(j) == fsm_q.wcnt) fsm_d.pbuf[j*DW +: DW] = word_in;
                        end
                        fsm_d.cnt  = '0;
                        fsm_d.wcnt = fsm_q.wcnt + CW'(1);
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + BW'(1);
                    end
                end
            end
            S_DROP: begin
                if (!sel_i) fsm_d.st = S_IDLE;
            end
            default: fsm_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    assign sdo_oe_o = sel_i && (fsm_q.status || (fsm_q.st == S_READ));
    assign sdo_o    = !sdo_oe_o ? 1'b0 : (fsm_q.status ? !busy_i : fsm_q.dout);

    // First bit shown after entering a read is the dummy zero (R3).
    p_dummy_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == S_READ) && ($past(fsm_q.st) == S_HDR)) |-> !fsm_q.dout);

    // While a programming result is pending, no instruction is framed (R9).
    p_status_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.status |-> (fsm_q.st == S_IDLE));
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
    parameter int AW          = 7,
    parameter int DW          = 16,
    parameter int PAGE_WORDS  = 4,
    parameter int PROG_CYCLES = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    localparam int CW = $clog2(PAGE_WORDS + 1);

    logic                 sel_s, sdi_s, rise_s, busy;
    logic [AW-1:0]        rd_addr, wr_base;
    logic [DW-1:0]        rd_data;
    logic                 commit, commit_all;
    logic [CW-1:0]        commit_cnt;
    logic [PAGE_WORDS*DW-1:0] commit_buf;

    mw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
        .sel_o(sel_s), .sdi_o(sdi_s), .rise_o(rise_s)
    );

    mw_cmd_fsm #(.AW(AW), .DW(DW), .PW(PAGE_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sel_i(sel_s), .sdi_i(sdi_s), .rise_i(rise_s), .busy_i(busy),
        .rd_data_i(rd_data), .rd_addr_o(rd_addr),
        .commit_o(commit), .commit_all_o(commit_all),
        .commit_base_o(wr_base), .commit_cnt_o(commit_cnt),
        .commit_buf_o(commit_buf),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy)
    );

    mw_mem_array #(.AW(AW), .DW(DW), .PW(PAGE_WORDS)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .wr_en_i(commit), .wr_all_i(commit_all),
        .wr_base_i(wr_base), .wr_cnt_i(commit_cnt), .wr_buf_i(commit_buf)
    );

    // A committed write always opens a busy window (R8).
    p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // No write is committed while programming is pending (R9).
    p_commit_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);

    // Each instruction commits at most once (R5).
    p_commit_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // Output enable follows the synchronised select (R11).
    p_oe_needs_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |-> !sdo_oe);
endmodule

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int PROG       = 200;
    localparam int WORDS      = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 0;

    logic [15:0] model [WORDS];
    logic [15:0] wbuf  [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_slave #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h0123) ^ 16'hA55A);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic q);
        sdi = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        q = sdo;
        sclk = 1'b0;
    endtask

    task automatic send(input logic [15:0] v, input int n);
        logic q;
        for (int i = n - 1; i >= 0; i--) bit_io(v[i], q);
    endtask

    task automatic begin_cmd();
        sel = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic end_cmd();
        sel = 1'b0;
        sdi = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_prog();
        repeat (PROG + 20) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [6:0] a);
        send(16'h1, 1);
        send({14'd0, op}, 2);
        send({9'd0, a}, 7);
    endtask

    task automatic send_data(input int nbits);
        logic q;
        for (int k = 0; k < nbits; k++) bit_io(wbuf[k/16][15-(k%16)], q);
    endtask

    task automatic read_words(input string req, input int a, input int n, input int lead);
        logic q;
        logic [15:0] w;
        begin_cmd();
        send(16'h0, lead);
        send(16'h1, 1);
        send(16'h2, 2);
        send(16'(a >> 1), 6);
        bit_io(a[0], q);
        chk({req, " R3 dummy"}, {sdo_oe, q}, 2'b10);
        for (int i = 0; i < n; i++) begin
            w = '0;
            for (int b = 0; b < 16; b++) begin
                bit_io(1'b0, q);
                w = {w[14:0], q};
            end
            chk(req, w, model[(a + i) % WORDS]);
        end
        end_cmd();
    endtask

    task automatic check_idle_oe(input string req);
        begin_cmd();
        chk(req, sdo_oe, 1'b0);
        end_cmd();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 / R11: reset state
        chk("R1 oe after reset", sdo_oe, 1'b0);
        chk("R11 oe sel low", sdo_oe, 1'b0);
        read_words("R1 reset word", 5, 1, 0);

        // R7 / R8: write-all with busy then ready status
        wbuf[0] = 16'h5A3C;
        begin_cmd();
        send_hdr(2'b00, 7'h20);
        send_data(16);
        sel = 1'b0;
        repeat (4) @(negedge clk);
        sel = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 busy", {sdo_oe, sdo}, 2'b10);
        repeat (PROG) @(negedge clk);
        chk("R8 ready", {sdo_oe, sdo}, 2'b11);
        sel = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11 oe after status", sdo_oe, 1'b0);
        for (int i = 0; i < WORDS; i++) model[i] = 16'h5A3C;
        read_words("R7 wrall low", 0, 1, 0);
        read_words("R7 wrall high", 127, 1, 0);

        // R6: fill the array with page writes
        for (int p = 0; p < WORDS / 4; p++) begin
            for (int j = 0; j < 4; j++) begin
                wbuf[j] = pat(4 * p + j);
                model[4 * p + j] = pat(4 * p + j);
            end
            begin_cmd();
            send_hdr(2'b11, 7'(4 * p));
            send_data(64);
            end_cmd();
            wait_prog();
        end

        // R3 / R4 / R6: full streaming read crossing the wrap point
        read_words("R4 stream", 0, WORDS + 2, 0);

        // R2: leading zeros before the start bit
        read_words("R2 leading zeros", 77, 1, 3);

        // R5: single write with extra bits ignored
        wbuf[0] = 16'hC0DE;
        wbuf[1] = 16'hFFFF;
        begin_cmd();
        send_hdr(2'b01, 7'd9);
        send_data(21);
        end_cmd();
        wait_prog();
        model[9] = 16'hC0DE;
        read_words("R5 write", 8, 3, 0);

        // R6: page wrap 127 -> 0
        wbuf[0] = 16'h1111;
        wbuf[1] = 16'h2222;
        begin_cmd();
        send_hdr(2'b11, 7'd127);
        send_data(32);
        end_cmd();
        wait_prog();
        model[127] = 16'h1111;
        model[0]   = 16'h2222;
        read_words("R6 page wrap", 126, 4, 0);

        // R6: fifth word beyond page ignored
        for (int j = 0; j < 5; j++) wbuf[j] = 16'h7000 + 16'(j);
        begin_cmd();
        send_hdr(2'b11, 7'd40);
        send_data(80);
        end_cmd();
        wait_prog();
        for (int j = 0; j < 4; j++) model[40 + j] = 16'h7000 + 16'(j);
        read_words("R6 page limit", 40, 5, 0);

        // R10: header abort
        begin_cmd();
        send(16'h1, 1);
        send(16'h1, 2);
        send(16'h3, 3);
        end_cmd();
        check_idle_oe("R10 no busy hdr");
        // R10: mid-word abort on single write
        wbuf[0] = 16'hDEAD;
        begin_cmd();
        send_hdr(2'b01, 7'd60);
        send_data(10);
        end_cmd();
        check_idle_oe("R10 no busy data");
        // R10: page with a partial second word
        wbuf[0] = 16'hBEEF;
        wbuf[1] = 16'hBEEF;
        begin_cmd();
        send_hdr(2'b11, 7'd50);
        send_data(19);
        end_cmd();
        check_idle_oe("R10 no busy page");
        read_words("R10 unchanged 60", 60, 1, 0);
        read_words("R10 unchanged 50", 50, 2, 0);

        // R2: extended code other than write-all has no effect
        wbuf[0] = 16'h0F0F;
        begin_cmd();
        send_hdr(2'b00, 7'h00);
        send_data(16);
        end_cmd();
        check_idle_oe("R2 ext noop");
        begin_cmd();
        send_hdr(2'b00, 7'h60);
        send_data(16);
        end_cmd();
        check_idle_oe("R2 ext noop b");
        read_words("R2 ext unchanged", 0, 1, 0);
        read_words("R2 ext unchanged hi", 127, 1, 0);

        // R9: instruction while busy ignored
        wbuf[0] = 16'h2020;
        begin_cmd();
        send_hdr(2'b01, 7'd20);
        send_data(16);
        end_cmd();
        model[20] = 16'h2020;
        wbuf[0] = 16'h2121;
        begin_cmd();
        send_hdr(2'b01, 7'd21);
        send_data(16);
        end_cmd();
        wait_prog();
        read_words("R9 busy ignore", 20, 2, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule